// File: doc/BRIEF.md
# Microcode Issue Takeover Sequencer

The block sits between the producer of decoded micro-operations and a single-wide issue port. Incoming entries go into a first-in first-out queue. An ordinary entry carries one micro-operation and is passed to issue unchanged. An instruction that expands to more than four micro-operations is stored as a single pointer entry that holds a start address in an internal microcode ROM. Instructions of four or fewer micro-operations arrive as ordinary entries.

When a pointer reaches the queue head, it is removed without being issued. The sequencer then owns the issue port and streams ROM words from the start address upward until the word marked as the routine's end has issued. Issue then falls back to the queue head. The producer may keep writing into the queue while the ROM owns issue. Two event counters are kept: one counts switches to the ROM, and the other counts entries written into the queue while the sequencer is busy.

Top module: `ucode_issue_ctrl`

## Requirements
- R1: While and right after reset, issue_valid and seq_busy are low, in_ready is high and both event counters read zero.
- R2: An entry written with in_is_ptr=0 issues with its 16-bit payload unchanged and issue_from_rom=0. Entries issue in the order they were written.
- R3: An entry written with in_is_ptr=1 is never issued itself. Its low 6 payload bits give a start address s. The block issues ROM words s, s+1 and onward with issue_from_rom=1, up to and including the first address whose low 3 bits are 111. ROM word a carries the payload 16'hC000 | a.
- R4: After the last word of a routine has issued, issue resumes with the next queue entry in write order.
- R5: While issue_valid is high and issue_ready is low, issue_valid stays high and issue_uop and issue_from_rom hold their values. Neither the queue nor the ROM address advances.
- R6: The queue holds 56 entries. in_ready is low exactly when 56 entries are held. Writes are still accepted while the sequencer is busy.
- R7: When no entry is held and the sequencer is idle, issue_valid is low.
- R8: If a pointer is at the queue head when a routine's last word issues, the first word of the new routine is offered in the next cycle, with no cycle of issue_valid low.
- R9: switch_count increases by one for each pointer entry taken from the queue head.
- R10: busy_write_count increases by one for each write accepted in a cycle where seq_busy is high.
- R11: A pointer that reaches the head while the sequencer is idle costs exactly one cycle with issue_valid low. That cycle is the one after its write, and the first ROM word is offered in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers an entry |
| in_ready | output | 1 | Queue has room for the entry |
| in_is_ptr | input | 1 | Entry is a ROM pointer |
| in_payload | input | 16 | Micro-op, or ROM start address in the low bits |
| issue_valid | output | 1 | A micro-op is offered to issue |
| issue_ready | input | 1 | Issue stage accepts the offered micro-op |
| issue_uop | output | 16 | Offered micro-op |
| issue_from_rom | output | 1 | Offered micro-op comes from the ROM |
| seq_busy | output | 1 | Sequencer owns the issue port |
| switch_count | output | 32 | Number of switches to the ROM |
| busy_write_count | output | 32 | Writes accepted while the sequencer is busy |

## Verification
Two events can land in the same clock edge.
- **Last ROM word and next pointer.** A routine's last word can be accepted in the same cycle that the next pointer is popped and its start address loaded. This is provoked by writing two pointers back to back with issue_ready held high. The bench then requires the fire cycles of both routines to form one unbroken run.
- **Producer write during ROM issue.** A producer write can coincide with a ROM-owned issue cycle, with a stalled issue and with a full queue. Random traffic with random back-pressure creates all of these. Each issued micro-op is compared against an expansion that the bench builds at write time, and the busy-write count is compared against writes tallied while seq_busy was observed high.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  // Constant ROM image: the payload of a word at a given address.
  function automatic logic [31:0] rom_payload(input int unsigned addr,
                                              input int unsigned tag);
    return 32'(tag) | 32'(addr);
  endfunction

  // Constant ROM image: a routine ends on the last word of each aligned segment.
  function automatic logic rom_is_end(input int unsigned addr,
                                      input int unsigned seg_log2);
    return ((addr + 1) % (1 << seg_log2)) == 0;
  endfunction

endpackage

// File: rtl/ucseq_fifo.sv
module ucseq_fifo #(
  parameter int DEPTH = 56,
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  output logic             push_ok,
  input  logic             pop,
  output logic             head_valid,
  output logic [WIDTH-1:0] head_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign push_ready = (count != FULL);
  assign push_ok    = push_valid && push_ready;
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];

  // Storage without reset, so that the tool can map it to RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);

  // R6
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && !pop) |=> (count == FULL));

endmodule

// File: rtl/ucseq_walker.sv
module ucseq_walker
  import ucseq_pkg::*;
#(
  parameter int ROM_AW   = 6,
  parameter int PW       = 16,
  parameter int SEG_LOG2 = 3,
  parameter int ROM_TAG  = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic              head_is_ptr,
  input  logic [ROM_AW-1:0] head_start,
  input  logic              issue_ready,
  output logic              busy,
  output logic              load,
  output logic [PW-1:0]     rom_uop,
  output logic              rom_last
);
  localparam int ROM_DEPTH = 1 << ROM_AW;

  logic [PW:0]       rom_img [ROM_DEPTH];
  logic [ROM_AW-1:0] rom_addr;
  logic              fire;

  // Constant ROM image, computed while the design is elaborated.
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    localparam logic [31:0] PAY = rom_payload(g, ROM_TAG);
    localparam logic        ENDW = rom_is_end(g, SEG_LOG2) || (g == ROM_DEPTH - 1);
    assign rom_img[g] = {ENDW, PAY[PW-1:0]};
  end

  assign rom_uop  = rom_img[rom_addr][PW-1:0];
  assign rom_last = rom_img[rom_addr][PW];
  assign fire     = busy && issue_ready;
  assign load     = head_valid && head_is_ptr && (!busy || (fire && rom_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rom_addr <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      rom_addr <= head_start;
    end else if (fire) begin
      if (rom_last) busy <= 1'b0;
      else          rom_addr <= rom_addr + 1'b1;
    end
  end

  // R5
  rom_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !issue_ready) |=> (busy && $stable(rom_addr)));

  // R3
  rom_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && issue_ready && !rom_last) |=> (busy && rom_addr == $past(rom_addr) + 1'b1));

  // R8
  chain_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && issue_ready && rom_last && head_valid && head_is_ptr) |=> busy);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && issue_ready && rom_last && !(head_valid && head_is_ptr)) |=> !busy);

endmodule

// File: rtl/ucseq_events.sv
module ucseq_events #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_ev,
  input  logic          seq_busy,
  input  logic          write_ev,
  output logic [CW-1:0] switch_count,
  output logic [CW-1:0] busy_write_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      switch_count     <= '0;
      busy_write_count <= '0;
    end else begin
      if (take_ev)              switch_count     <= switch_count + 1'b1;
      if (write_ev && seq_busy) busy_write_count <= busy_write_count + 1'b1;
    end
  end

  // R9
  switch_inc_chk: assert property (@(posedge clk) disable iff (rst)
    take_ev |=> (switch_count == $past(switch_count) + 1'b1));

  // R10
  busy_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !seq_busy |=> $stable(busy_write_count));

endmodule

// File: rtl/ucode_issue_ctrl.sv
module ucode_issue_ctrl #(
  parameter int Q_DEPTH  = 56,
  parameter int PW       = 16,
  parameter int ROM_AW   = 6,
  parameter int SEG_LOG2 = 3,
  parameter int ROM_TAG  = 16'hC000,
  parameter int CW       = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_is_ptr,
  input  logic [PW-1:0] in_payload,
  output logic          issue_valid,
  input  logic          issue_ready,
  output logic [PW-1:0] issue_uop,
  output logic          issue_from_rom,
  output logic          seq_busy,
  output logic [CW-1:0] switch_count,
  output logic [CW-1:0] busy_write_count
);
  localparam int EW = PW + 1;

  logic          push_ok, pop, head_valid, head_is_ptr, load, rom_last;
  logic [EW-1:0] head_data;
  logic [PW-1:0] head_payload, rom_uop;
  logic          q_fire;

  ucseq_fifo #(.DEPTH(Q_DEPTH), .WIDTH(EW)) fifo_i (
    .clk        (clk),
    .rst        (rst),
    .push_valid (in_valid),
    .push_data  ({in_is_ptr, in_payload}),
    .push_ready (in_ready),
    .push_ok    (push_ok),
    .pop        (pop),
    .head_valid (head_valid),
    .head_data  (head_data)
  );

  assign head_is_ptr  = head_data[PW];
  assign head_payload = head_data[PW-1:0];

  ucseq_walker #(.ROM_AW(ROM_AW), .PW(PW), .SEG_LOG2(SEG_LOG2), .ROM_TAG(ROM_TAG)) walker_i (
    .clk         (clk),
    .rst         (rst),
    .head_valid  (head_valid),
    .head_is_ptr (head_is_ptr),
    .head_start  (head_payload[ROM_AW-1:0]),
    .issue_ready (issue_ready),
    .busy        (seq_busy),
    .load        (load),
    .rom_uop     (rom_uop),
    .rom_last    (rom_last)
  );

  ucseq_events #(.CW(CW)) events_i (
    .clk              (clk),
    .rst              (rst),
    .take_ev          (load),
    .seq_busy         (seq_busy),
    .write_ev         (push_ok),
    .switch_count     (switch_count),
    .busy_write_count (busy_write_count)
  );

  // Source mux: the ROM owns issue while busy, otherwise the queue head does.
  assign q_fire         = !seq_busy && head_valid && !head_is_ptr && issue_ready;
  assign pop            = load || q_fire;
  assign issue_valid    = seq_busy || (head_valid && !head_is_ptr);
  assign issue_uop      = seq_busy ? rom_uop : head_payload;
  assign issue_from_rom = seq_busy;

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && !head_valid) |-> !issue_valid);

  // R3
  ptr_not_issued_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_from_rom) |-> !head_is_ptr);

  // R5
  queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready && !seq_busy) |=> (issue_valid && $stable(issue_uop)));

endmodule

// File: tb/ucode_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module ucode_issue_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_is_ptr = 1'b0, issue_ready = 1'b0;
  logic [15:0] in_payload = '0;
  logic        in_ready, issue_valid, issue_from_rom, seq_busy;
  logic [15:0] issue_uop;
  logic [31:0] switch_count, busy_write_count;

  int          checks = 0, fails = 0, cyc = 0;
  logic [16:0] exp_q[$];
  int          sw_exp = 0, bw_exp = 0;
  bit          prev_stall = 1'b0, prev_rom = 1'b0, last_rom_fire = 1'b0;
  logic [16:0] prev_out;
  int          first_fire = -1, last_fire = -1, nfire = 0, gaps = 0;

  always #2.5 clk = ~clk;

  ucode_issue_ctrl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_ptr(in_is_ptr), .in_payload(in_payload), .issue_valid(issue_valid),
    .issue_ready(issue_ready), .issue_uop(issue_uop), .issue_from_rom(issue_from_rom),
    .seq_busy(seq_busy), .switch_count(switch_count), .busy_write_count(busy_write_count)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Expected expansion of one written entry, from R2 and R3.
  task automatic expand(input bit p, input logic [15:0] d);
    if (!p) exp_q.push_back({1'b0, d});
    else begin
      for (int a = int'(d[5:0]); a < 64; a++) begin
        exp_q.push_back({1'b1, 16'hC000 | 16'(a)});
        if (a % 8 == 7) break;
      end
    end
  endtask

  task automatic cycle(input bit v, input bit p, input logic [15:0] d, input bit r);
    logic [16:0] e;
    @(negedge clk);
    in_valid = v; in_is_ptr = p; in_payload = d; issue_ready = r;
    #1;
    if (prev_stall)  // R5
      check(issue_valid && {issue_from_rom, issue_uop} == prev_out, "R5 hold",
            {15'd0, issue_from_rom, issue_uop}, {15'd0, prev_out});
    if (exp_q.size() == 0)  // R7
      check(!issue_valid, "R7 idle", 32'(issue_valid), 32'd0);
    if (issue_valid && issue_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 extra issue", 32'(issue_uop), 32'd0);
      else begin
        e = exp_q.pop_front();
        if (e[16])
          check({issue_from_rom, issue_uop} == e, "R3 rom word",
                {15'd0, issue_from_rom, issue_uop}, {15'd0, e});
        else if (last_rom_fire)
          check({issue_from_rom, issue_uop} == e, "R4 resume",
                {15'd0, issue_from_rom, issue_uop}, {15'd0, e});
        else
          check({issue_from_rom, issue_uop} == e, "R2 queue word",
                {15'd0, issue_from_rom, issue_uop}, {15'd0, e});
      end
      last_rom_fire = issue_from_rom;
      if (first_fire < 0) first_fire = cyc;
      last_fire = cyc;
      nfire++;
    end else if (first_fire >= 0 && !issue_valid) gaps++;
    if (in_valid && in_ready) begin
      expand(p, d);
      if (seq_busy) bw_exp++;
      if (p) sw_exp++;
    end
    prev_stall = issue_valid && !issue_ready;
    prev_out   = {issue_from_rom, issue_uop};
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) cycle(0, 0, 16'h0, 1);
    for (int i = 0; i < 3; i++) cycle(0, 0, 16'h0, 1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int acc;
    int c0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    // R1
    check(!issue_valid, "R1 valid", 32'(issue_valid), 0);
    check(in_ready, "R1 ready", 32'(in_ready), 1);
    check(!seq_busy, "R1 busy", 32'(seq_busy), 0);
    check(switch_count == 0 && busy_write_count == 0, "R1 counters",
          switch_count | busy_write_count, 0);

    // R6: fill with issue stalled.
    acc = 0;
    for (int i = 0; i < 60; i++) begin
      cycle(1, 0, 16'(16'h1000 + i), 0);
      if (in_ready) acc++;
    end
    #1;
    check(acc == 56, "R6 capacity", 32'(acc), 32'd56);
    check(!in_ready, "R6 full ready", 32'(in_ready), 0);
    drain();

    // R8 / R11: two pointers back to back.
    first_fire = -1; nfire = 0; gaps = 0;
    c0 = cyc;
    cycle(1, 1, 16'h0005, 1);
    cycle(1, 1, 16'h0010, 1);
    for (int i = 0; i < 20; i++) cycle(0, 0, 16'h0, 1);
    check(first_fire == c0 + 2, "R11 one bubble", 32'(first_fire - c0), 32'd2);
    check(nfire == 11 && last_fire - first_fire + 1 == 11, "R8 chained routines",
          32'(last_fire - first_fire + 1), 32'd11);

    // R10: writes while the ROM owns issue and issue is stalled.
    cycle(1, 1, 16'h0000, 0);
    cycle(0, 0, 16'h0, 0);
    for (int i = 0; i < 3; i++) cycle(1, 0, 16'(16'h2000 + i), 0);
    drain();

    // Random traffic.
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 100) < 60;
      bit p = ($urandom % 100) < 15;
      bit r = ($urandom % 100) < 70;
      cycle(v, p, 16'($urandom), r);
    end
    drain();

    check(exp_q.size() == 0, "R4 all issued", 32'(exp_q.size()), 0);
    check(switch_count == 32'(sw_exp), "R9 switches", switch_count, 32'(sw_exp));
    check(busy_write_count == 32'(bw_exp), "R10 busy writes", busy_write_count, 32'(bw_exp));
    finish_run();
  end
endmodule